// File: doc/BRIEF.md
# Receive Symbol-Pair to Byte-Wide Code Encoder

This block sits on the receive path between the symbol decoder and the MAC. On each byte clock it takes one pair of decoded 4-bit symbols, each with its control flag, and turns it into a 9-bit code for the indication port. The code is one control bit and eight data bits, and the block registers it once per byte clock.

While the line is in Active Line State, the symbols themselves pass through. When a pair mixes one data symbol and one control symbol, the data nibble is cleared. In every other line state the byte carries line status: a receive-state nibble, a bit that flags whether the pair fits the current line state, and the 3-bit line state. Three side conditions override the normal code. These are an elasticity-buffer overflow or underflow, a connection-unavailable indication, and a stuff byte that arrives during Idle Line State. Line-state detection and parity generation are done elsewhere.

Top module: `phy_byte_encoder`

## Requirements
- R1: In Active Line State (line state 000), a pair of two data symbols (both control flags 0) gives control bit 0 and byte {first nibble, second nibble}.
- R2: In Active Line State, a pair of two control symbols gives control bit 1 and byte {first nibble, second nibble}.
- R3: In Active Line State, a pair with exactly one control symbol gives control bit 1, with the data symbol's nibble replaced by 0000 and the control nibble kept in its position.
- R4: Outside Active Line State the control bit is 1 and the byte is {receive state[7:4], unknown[3], line state[2:0]}. The receive state is 1011 in Idle Line State (001) and 0011 in every other state. Line states are coded ALS=000, ILS=001, NSD=010, MLS=100, HLS=101, QLS=110, NLS=111.
- R5: The unknown bit is 0 only when the pair fits the line state, and 1 otherwise. In ILS both symbols must be control Idle (1010). In HLS both must be control Halt (0001). In QLS both must be control Quiet (0000). In MLS the pair must be one control Halt and one control Quiet, in either order. In NSD, NLS and the unused code 011 the bit is always 1.
- R6: A stuff byte during ILS gives control bit 1 and byte 1011_0_001 whatever the symbols are. Outside ILS the stuff flag has no effect.
- R7: An elasticity-buffer overflow/underflow gives control bit 1 and byte 0011_1011. It takes priority over every other input.
- R8: A connection-unavailable indication gives control bit 1 and byte 0011_1010. It yields only to R7 and takes priority over R6 and normal encoding.
- R9: While reset is asserted, the output is control bit 1 and byte 0011_1010.
- R10: The code for a pair appears on the output after the first rising clock edge at which the pair is presented, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| symHiCtl | input | 1 | First symbol is a control symbol |
| symHi | input | 4 | First decoded symbol |
| symLoCtl | input | 1 | Second symbol is a control symbol |
| symLo | input | 4 | Second decoded symbol |
| lineState | input | 3 | Current line state code |
| stuffByte | input | 1 | Pair is a stuff byte inserted by the elasticity buffer |
| bufSlip | input | 1 | Elasticity buffer overflow or underflow |
| linkDown | input | 1 | Connection unavailable |
| outCtl | output | 1 | Control bit of the byte-wide code |
| outByte | output | 8 | Data bits of the byte-wide code |

## Verification
The assertions assume the inputs are stable around each rising edge and have a known value in every cycle after reset, so that the strobes and symbols sampled by `$past` are the ones the register captured. The control flags are assumed to be the only thing that separates data symbols from control symbols. The stimulus changes every input only on the falling edge and sets every input in every scenario. It also holds reset long enough that the first sampled cycle starts from a defined register.

// File: rtl/phy_enc_pkg.sv
package phy_enc_pkg;

  localparam int NIB_W  = 4;
  localparam int LS_W   = 3;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [LS_W-1:0] LS_ACTIVE = 3'b000;
  localparam logic [LS_W-1:0] LS_IDLE   = 3'b001;
  localparam logic [LS_W-1:0] LS_NOSIG  = 3'b010;
  localparam logic [LS_W-1:0] LS_MASTER = 3'b100;
  localparam logic [LS_W-1:0] LS_HALT   = 3'b101;
  localparam logic [LS_W-1:0] LS_QUIET  = 3'b110;
  localparam logic [LS_W-1:0] LS_NOISE  = 3'b111;

  localparam logic [NIB_W-1:0] RX_IDLE    = 4'b1011;
  localparam logic [NIB_W-1:0] RX_INVALID = 4'b0011;

  localparam logic [BYTE_W-1:0] CODE_SLIP = 8'b0011_1011;
  localparam logic [BYTE_W-1:0] CODE_LINK = 8'b0011_1010;

  typedef enum logic [1:0] {
    ENC_SYM  = 2'd0,
    ENC_STAT = 2'd1,
    ENC_SLIP = 2'd2,
    ENC_LINK = 2'd3
  } encMode_t;

  typedef struct packed {
    encMode_t mode;
    logic     zeroHi;
    logic     zeroLo;
    logic     unknown;
  } encStrobe_t;

endpackage

// File: rtl/phy_enc_ctrl.sv
module phy_enc_ctrl
  import phy_enc_pkg::*;
#(
  parameter logic [NIB_W-1:0] IDLE_SYM  = 4'b1010,
  parameter logic [NIB_W-1:0] HALT_SYM  = 4'b0001,
  parameter logic [NIB_W-1:0] QUIET_SYM = 4'b0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              symHiCtl,
  input  logic [NIB_W-1:0]  symHi,
  input  logic              symLoCtl,
  input  logic [NIB_W-1:0]  symLo,
  input  logic [LS_W-1:0]   lineState,
  input  logic              stuffByte,
  input  logic              bufSlip,
  input  logic              linkDown,
  output encStrobe_t        strobe
);

  logic hiIdle, loIdle, hiHalt, loHalt, hiQuiet, loQuiet;
  logic pairFits;
  logic inActive, inIdle;

  assign hiIdle  = symHiCtl && (symHi == IDLE_SYM);
  assign loIdle  = symLoCtl && (symLo == IDLE_SYM);
  assign hiHalt  = symHiCtl && (symHi == HALT_SYM);
  assign loHalt  = symLoCtl && (symLo == HALT_SYM);
  assign hiQuiet = symHiCtl && (symHi == QUIET_SYM);
  assign loQuiet = symLoCtl && (symLo == QUIET_SYM);

  assign inActive = (lineState == LS_ACTIVE);
  assign inIdle   = (lineState == LS_IDLE);

  always_comb begin
    unique case (lineState)
      LS_IDLE:   pairFits = hiIdle && loIdle;
      LS_HALT:   pairFits = hiHalt && loHalt;
      LS_QUIET:  pairFits = hiQuiet && loQuiet;
      LS_MASTER: pairFits = (hiHalt && loQuiet) || (hiQuiet && loHalt);
      default:   pairFits = 1'b0;
    endcase
  end

  always_comb begin
    strobe.zeroHi  = inActive && !symHiCtl && symLoCtl;
    strobe.zeroLo  = inActive && symHiCtl && !symLoCtl;
    strobe.unknown = (inIdle && stuffByte) ? 1'b0 : !pairFits;
    if (bufSlip)       strobe.mode = ENC_SLIP;
    else if (linkDown) strobe.mode = ENC_LINK;
    else if (inActive) strobe.mode = ENC_SYM;
    else               strobe.mode = ENC_STAT;
  end

  // R3: at most one nibble of a pair is ever cleared
  assert_single_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.zeroHi && strobe.zeroLo));

  // R5: a pair that fits Idle Line State is never marked unknown
  assert_idle_known_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && hiIdle && loIdle) |-> !strobe.unknown);

endmodule

// File: rtl/phy_enc_datapath.sv
module phy_enc_datapath
  import phy_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strobe,
  input  logic              symHiCtl,
  input  logic [NIB_W-1:0]  symHi,
  input  logic              symLoCtl,
  input  logic [NIB_W-1:0]  symLo,
  input  logic [LS_W-1:0]   lineState,
  output logic              outCtl,
  output logic [BYTE_W-1:0] outByte
);

  logic              nextCtl;
  logic [BYTE_W-1:0] nextByte;
  logic [NIB_W-1:0]  hiNib, loNib, rxNib;

  assign hiNib = strobe.zeroHi ? '0 : symHi;
  assign loNib = strobe.zeroLo ? '0 : symLo;
  assign rxNib = (lineState == LS_IDLE) ? RX_IDLE : RX_INVALID;

  always_comb begin
    unique case (strobe.mode)
      ENC_SYM: begin
        nextCtl  = symHiCtl || symLoCtl;
        nextByte = {hiNib, loNib};
      end
      ENC_STAT: begin
        nextCtl  = 1'b1;
        nextByte = {rxNib, strobe.unknown, lineState};
      end
      ENC_SLIP: begin
        nextCtl  = 1'b1;
        nextByte = CODE_SLIP;
      end
      default: begin
        nextCtl  = 1'b1;
        nextByte = CODE_LINK;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCtl  <= 1'b1;
      outByte <= CODE_LINK;
    end else begin
      outCtl  <= nextCtl;
      outByte <= nextByte;
    end
  end

  // R1: a pure data pair passes through as a data byte
  assert_data_pair_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == ENC_SYM && !symHiCtl && !symLoCtl) |=>
      (!outCtl && outByte == {$past(symHi), $past(symLo)}));

  // R3: a mixed pair leaves a control byte with one cleared nibble
  assert_mix_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == ENC_SYM && (symHiCtl != symLoCtl)) |=>
      (outCtl && (outByte[7:4] == 4'd0 || outByte[3:0] == 4'd0)));

  // R4: a status byte carries the line state in its low bits
  assert_status_layout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == ENC_STAT) |=>
      (outCtl && outByte[2:0] == $past(lineState)));

  // R7: a buffer slip always yields its fixed code
  assert_slip_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == ENC_SLIP) |=> (outCtl && outByte == CODE_SLIP));

endmodule

// File: rtl/phy_byte_encoder.sv
module phy_byte_encoder
  import phy_enc_pkg::*;
#(
  parameter logic [3:0] IDLE_SYM  = 4'b1010,
  parameter logic [3:0] HALT_SYM  = 4'b0001,
  parameter logic [3:0] QUIET_SYM = 4'b0000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symHiCtl,
  input  logic [3:0] symHi,
  input  logic       symLoCtl,
  input  logic [3:0] symLo,
  input  logic [2:0] lineState,
  input  logic       stuffByte,
  input  logic       bufSlip,
  input  logic       linkDown,
  output logic       outCtl,
  output logic [7:0] outByte
);

  encStrobe_t strobe;

  phy_enc_ctrl #(
    .IDLE_SYM (IDLE_SYM),
    .HALT_SYM (HALT_SYM),
    .QUIET_SYM(QUIET_SYM)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .symHiCtl (symHiCtl),
    .symHi    (symHi),
    .symLoCtl (symLoCtl),
    .symLo    (symLo),
    .lineState(lineState),
    .stuffByte(stuffByte),
    .bufSlip  (bufSlip),
    .linkDown (linkDown),
    .strobe   (strobe)
  );

  phy_enc_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .symHiCtl (symHiCtl),
    .symHi    (symHi),
    .symLoCtl (symLoCtl),
    .symLo    (symLo),
    .lineState(lineState),
    .outCtl   (outCtl),
    .outByte  (outByte)
  );

  // R8: connection-unavailable without a slip yields its fixed code
  assert_link_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (linkDown && !bufSlip) |=> (outCtl && outByte == 8'b0011_1010));

endmodule

// File: tb/phy_byte_encoder_tb_top.sv
module phy_byte_encoder_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       symHiCtl, symLoCtl;
  logic [3:0] symHi, symLo;
  logic [2:0] lineState;
  logic       stuffByte, bufSlip, linkDown;
  logic       outCtl;
  logic [7:0] outByte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [3:0] SI = 4'b1010, SH = 4'b0001, SQ = 4'b0000;
  localparam logic [3:0] ST = 4'b0101, SR = 4'b0110, SJ = 4'b1101;

  always #5 clk = ~clk;

  phy_byte_encoder dut_i (
    .clk(clk), .rstN(rstN),
    .symHiCtl(symHiCtl), .symHi(symHi),
    .symLoCtl(symLoCtl), .symLo(symLo),
    .lineState(lineState), .stuffByte(stuffByte),
    .bufSlip(bufSlip), .linkDown(linkDown),
    .outCtl(outCtl), .outByte(outByte)
  );

  task automatic compare(input logic expC, input logic [7:0] expB, input string req);
    checks++;
    if (outCtl !== expC || outByte !== expB) begin
      errors++;
      $display("FAIL %s: actual ctl=%b byte=%b expected ctl=%b byte=%b",
               req, outCtl, outByte, expC, expB);
    end
  endtask

  task automatic drive(input logic hc, input logic [3:0] h, input logic lc, input logic [3:0] l,
                       input logic [2:0] ls, input logic st, input logic sl, input logic lk);
    @(negedge clk);
    symHiCtl = hc; symHi = h; symLoCtl = lc; symLo = l;
    lineState = ls; stuffByte = st; bufSlip = sl; linkDown = lk;
  endtask

  task automatic apply(input logic hc, input logic [3:0] h, input logic lc, input logic [3:0] l,
                       input logic [2:0] ls, input logic st, input logic sl, input logic lk,
                       input logic expC, input logic [7:0] expB, input string req);
    drive(hc, h, lc, l, ls, st, sl, lk);
    @(posedge clk); #1;
    compare(expC, expB, req);
  endtask

  task automatic test_reset;
    rstN = 1'b0;
    drive(1'b0, 4'h5, 1'b0, 4'h6, 3'b000, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1 compare(1'b1, 8'b0011_1010, "R9");
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic test_active;
    apply(0, 4'h3, 0, 4'hC, 3'b000, 0, 0, 0, 1'b0, 8'h3C, "R1");
    apply(0, 4'hF, 0, 4'h0, 3'b000, 0, 0, 0, 1'b0, 8'hF0, "R1");
    apply(1, SJ, 1, SJ, 3'b000, 0, 0, 0, 1'b1, 8'hDD, "R2");
    apply(1, ST, 1, SR, 3'b000, 0, 0, 0, 1'b1, 8'h56, "R2");
    apply(0, 4'h9, 1, ST, 3'b000, 0, 0, 0, 1'b1, 8'h05, "R3");
    apply(1, SR, 0, 4'h7, 3'b000, 0, 0, 0, 1'b1, 8'h60, "R3");
  endtask

  task automatic test_status;
    apply(1, SI, 1, SI, 3'b001, 0, 0, 0, 1'b1, 8'b1011_0_001, "R4 R5 ILS known");
    apply(1, SH, 1, SH, 3'b001, 0, 0, 0, 1'b1, 8'b1011_1_001, "R5 ILS HH");
    apply(1, SI, 0, 4'h2, 3'b001, 0, 0, 0, 1'b1, 8'b1011_1_001, "R5 ILS mixed");
    apply(0, SI, 0, SI, 3'b001, 0, 0, 0, 1'b1, 8'b1011_1_001, "R5 ILS data 1010");
    apply(1, SH, 1, SH, 3'b101, 0, 0, 0, 1'b1, 8'b0011_0_101, "R4 R5 HLS HH");
    apply(1, SI, 1, SI, 3'b101, 0, 0, 0, 1'b1, 8'b0011_1_101, "R5 HLS II");
    apply(1, SQ, 1, SQ, 3'b110, 0, 0, 0, 1'b1, 8'b0011_0_110, "R5 QLS QQ");
    apply(1, SH, 1, SQ, 3'b100, 0, 0, 0, 1'b1, 8'b0011_0_100, "R5 MLS HQ");
    apply(1, SQ, 1, SH, 3'b100, 0, 0, 0, 1'b1, 8'b0011_0_100, "R5 MLS QH");
    apply(1, SH, 1, SH, 3'b100, 0, 0, 0, 1'b1, 8'b0011_1_100, "R5 MLS HH");
    apply(1, SQ, 1, SQ, 3'b010, 0, 0, 0, 1'b1, 8'b0011_1_010, "R5 NSD");
    apply(1, SI, 1, SI, 3'b111, 0, 0, 0, 1'b1, 8'b0011_1_111, "R5 NLS");
  endtask

  task automatic test_stuff;
    apply(1, SH, 0, 4'h4, 3'b001, 1, 0, 0, 1'b1, 8'b1011_0_001, "R6 ILS stuff");
    apply(1, SH, 1, SH, 3'b101, 1, 0, 0, 1'b1, 8'b0011_0_101, "R6 stuff ignored HLS");
    apply(1, SI, 1, SI, 3'b101, 1, 0, 0, 1'b1, 8'b0011_1_101, "R6 stuff ignored HLS II");
    apply(0, 4'h1, 0, 4'h2, 3'b000, 1, 0, 0, 1'b0, 8'h12, "R6 stuff ignored ALS");
  endtask

  task automatic test_override;
    apply(0, 4'h1, 0, 4'h2, 3'b000, 0, 1, 0, 1'b1, 8'b0011_1011, "R7 slip ALS");
    apply(1, SI, 1, SI, 3'b001, 1, 1, 1, 1'b1, 8'b0011_1011, "R7 slip over all");
    apply(1, SH, 1, SH, 3'b101, 0, 0, 1, 1'b1, 8'b0011_1010, "R8 link HLS");
    apply(1, SI, 1, SI, 3'b001, 1, 0, 1, 1'b1, 8'b0011_1010, "R8 link over stuff");
    apply(0, 4'hA, 0, 4'hB, 3'b000, 0, 0, 1, 1'b1, 8'b0011_1010, "R8 link ALS");
  endtask

  task automatic test_latency;
    apply(0, 4'h1, 0, 4'h1, 3'b000, 0, 0, 0, 1'b0, 8'h11, "R10 setup");
    drive(0, 4'hE, 0, 4'h8, 3'b000, 0, 0, 0);
    #1 compare(1'b0, 8'h11, "R10 held before edge");
    @(posedge clk); #1;
    compare(1'b0, 8'hE8, "R10 after one edge");
  endtask

  initial begin
    rstN = 1'b0;
    symHiCtl = 0; symHi = 0; symLoCtl = 0; symLo = 0;
    lineState = 0; stuffByte = 0; bufSlip = 0; linkDown = 0;
    test_reset();
    test_active();
    test_status();
    test_stuff();
    test_override();
    test_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule